// File: doc/BRIEF.md
# Shadow-Buffered Waveform Generator

This block drives one pulse-width-modulated output from a 32-bit up-counter. Software programs a period and a compare value through a small word-addressed register port. Writes use byte strobes, and reads return data in the same cycle. The period and compare values in force are held in two active registers. Two shadow registers sit beside them. Each time the counter wraps, the shadow contents replace the active ones. Software can therefore retune a running waveform by writing the shadows, and the period already under way finishes unchanged. While the counter is stopped, software writes the active registers directly.

A 16-bit control register sits in the upper half of a word and holds four settings. The mode bit gates the output. The polarity bit decides whether the compare value sets the high time or the low time. The run bit starts and freezes the counter. A two-bit field decides whether a synchronisation input may restart the counter. The output is produced by a three-state machine: `WV_OFF` (forced low), `WV_HIGH` and `WV_LOW`. The machine is re-evaluated on every clock, and its transitions are:
- any state to `WV_OFF` when the mode bit is clear;
- any state to `WV_HIGH` when the mode bit is set and the phase comparison, after any polarity inversion, calls for the active level;
- any state to `WV_LOW` otherwise.

Top module: `shadow_pwm`

## Requirements
- R1: After reset, every mapped register reads zero, the counter is stopped and `pwm_out` is low.
- R2: The word addresses are as follows:
  - word 2: active period;
  - word 3: active compare;
  - word 4: shadow period;
  - word 5: shadow compare;
  - word 10: control, held in bits 31:16 and written through strobe lanes 2 and 3.

  A write changes only the byte lanes whose strobe bit is set. Reading a mapped word returns its contents, control bits 15:0 of word 10 read zero, and unmapped words read zero.
- R3: When control bit 4 is set, the counter steps by one each clock from 0 up to the active period and then returns to 0, so one cycle lasts period+1 clocks. When bit 4 is clear, the counter holds its value.
- R4: With control bit 10 clear, the output is high while the counter is below the active compare value and low otherwise. A compare of 0 gives a constant low, and a compare above the period gives a constant high.
- R5: With control bit 10 set, the output levels of R4 are inverted: the compare value sets the length of the low phase.
- R6: When control bit 9 is clear, `pwm_out` is low from the first clock edge after the control register changes, whatever the counter, compare and polarity.
- R7: The shadow registers are copied into the active registers only on the clock at which the counter returns from the period to 0. A shadow write leaves the current cycle unchanged, and a shadow write made while the counter is stopped has no effect on the output.
- R8: A write to an active register takes effect at once, including while the counter is stopped. A bus write wins over a copy from the shadows in the same clock.
- R9: A period of 1 with a compare of 1 gives a repeating two-clock waveform, high for one clock.
- R10: When control bits 7:6 are both set, `sync_in` is ignored. Under any other encoding, a high `sync_in` while the counter runs returns the counter to 0 with no shadow copy.
- R11: `pwm_out` is registered. Its level after a clock edge reflects the counter value held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Write data |
| wr_strb | input | DATA_W/8 | Byte-lane write strobes |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_data | output | DATA_W | Read data, same cycle |
| sync_in | input | 1 | Counter restart request |
| pwm_out | output | 1 | Waveform output |

## Verification
The assertions check the following on every clock:
- a stopped counter stays frozen;
- a running counter only steps by one or returns to zero;
- with synchronisation disabled, the counter never leaves its step early;
- the active registers change only on a wrap or on a direct write;
- a cleared mode bit is followed by a low output.

The remaining behaviours need the bench's scenarios. These are the measured duty and period under both polarities, the boundary compare values, the two-clock minimum cycle, a retune made mid-cycle that must appear only after the wrap, direct writes while stopped, and the effect of a sync pulse under each encoding.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

    // Word addresses (byte offset / 4)
    localparam int WA_ACT_PER = 2;
    localparam int WA_ACT_CMP = 3;
    localparam int WA_SHD_PER = 4;
    localparam int WA_SHD_CMP = 5;
    localparam int WA_CTRL    = 10;

    // Number of period/compare words, active pair first, then shadow pair
    localparam int NUM_TIMING_REGS = 4;
    localparam int NUM_ACTIVE      = 2;

    // Control register sits in byte lanes 2 and 3 of its word
    localparam int CTRL_W       = 16;
    localparam int CTRL_LANE_LO = 2;

    // Control bit positions
    localparam int CB_RUN     = 4;
    localparam int CB_SYNC_LO = 6;
    localparam int CB_SYNC_HI = 7;
    localparam int CB_MODE    = 9;
    localparam int CB_POL     = 10;

    typedef enum logic [1:0] {
        WV_OFF  = 2'b00,
        WV_HIGH = 2'b01,
        WV_LOW  = 2'b10
    } wave_state_e;

    typedef struct packed {
        logic mode;
        logic pol;
        logic run;
        logic sync_dis;
    } ctrl_dec_t;

    function automatic ctrl_dec_t decode_ctrl(input logic [CTRL_W-1:0] c);
        ctrl_dec_t d;
        d.mode     = c[CB_MODE];
        d.pol      = c[CB_POL];
        d.run      = c[CB_RUN];
        d.sync_dis = c[CB_SYNC_HI] & c[CB_SYNC_LO];
        return d;
    endfunction

endpackage

// File: rtl/spwm_regs.sv
module spwm_regs
    import spwm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [DATA_W/8-1:0]  wr_strb,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    input  logic                 wrap,
    output logic [DATA_W-1:0]    act_per,
    output logic [DATA_W-1:0]    act_cmp,
    output logic [CTRL_W-1:0]    ctrl
);

    localparam int NLANE = DATA_W / 8;

    logic [DATA_W-1:0]          tim_q [NUM_TIMING_REGS];
    logic [NUM_TIMING_REGS-1:0] tim_hit;
    logic                       ctrl_hit;
    logic [CTRL_W-1:0]          ctrl_q;

    function automatic logic [DATA_W-1:0] lane_merge(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic [NLANE-1:0]  strb
    );
        logic [DATA_W-1:0] r;
        r = old_v;
        for (int b = 0; b < NLANE; b++) begin
            if (strb[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
        end
        return r;
    endfunction

    // One decoded write strobe per timing word
    for (genvar i = 0; i < NUM_TIMING_REGS; i++) begin : g_hit
        assign tim_hit[i] = wr_en && (|wr_strb) &&
                            (wr_addr == ADDR_W'(WA_ACT_PER + i));
    end

    assign ctrl_hit = wr_en && (wr_addr == ADDR_W'(WA_CTRL));

    // Timing words: bus write first, then wrap copy for the active pair
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_TIMING_REGS; i++) tim_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_TIMING_REGS; i++) begin
                if (tim_hit[i]) begin
                    tim_q[i] <= lane_merge(tim_q[i], wr_data, wr_strb);
                end else if ((i < NUM_ACTIVE) && wrap) begin
                    tim_q[i] <= tim_q[(i + NUM_ACTIVE) % NUM_TIMING_REGS];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_hit) begin
            if (wr_strb[CTRL_LANE_LO])
                ctrl_q[7:0]  <= wr_data[8*CTRL_LANE_LO +: 8];
            if (wr_strb[CTRL_LANE_LO+1])
                ctrl_q[15:8] <= wr_data[8*(CTRL_LANE_LO+1) +: 8];
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_W'(WA_ACT_PER): rd_data = tim_q[0];
            ADDR_W'(WA_ACT_CMP): rd_data = tim_q[1];
            ADDR_W'(WA_SHD_PER): rd_data = tim_q[2];
            ADDR_W'(WA_SHD_CMP): rd_data = tim_q[3];
            ADDR_W'(WA_CTRL):    rd_data[8*CTRL_LANE_LO +: CTRL_W] = ctrl_q;
            default:             rd_data = '0;
        endcase
    end

    assign act_per = tim_q[0];
    assign act_cmp = tim_q[1];
    assign ctrl    = ctrl_q;

    AST_ACT_PER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap && !tim_hit[0]) |=> $stable(tim_q[0])); // R7
    AST_ACT_CMP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap && !tim_hit[1]) |=> $stable(tim_q[1])); // R7

endmodule

// File: rtl/spwm_timebase.sv
module spwm_timebase #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              sync_in,
    input  logic              sync_dis,
    input  logic [DATA_W-1:0] per,
    output logic [DATA_W-1:0] cnt,
    output logic              wrap
);

    logic [DATA_W-1:0] cnt_q;
    logic              sync_hit;

    always_comb begin
        sync_hit = run && sync_in && !sync_dis;
        // >= so a period shortened below the count still wraps at once
        wrap     = run && !sync_hit && (cnt_q >= per);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run) begin
            if (sync_hit || wrap) cnt_q <= '0;
            else                  cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt_q)); // R3
    AST_STEP_OR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == '0))); // R3
    AST_SYNC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (run && sync_dis && (cnt_q < per)) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R10

endmodule

// File: rtl/spwm_wave.sv
module spwm_wave
    import spwm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] cnt,
    input  logic [DATA_W-1:0] cmp,
    input  logic              mode,
    input  logic              pol,
    output logic              pwm_out
);

    wave_state_e state_q, state_d;
    logic        in_phase;

    always_comb begin
        in_phase = (cnt < cmp);
        if (!mode)                state_d = WV_OFF;
        else if (in_phase ^ pol)  state_d = WV_HIGH;
        else                      state_d = WV_LOW;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WV_OFF;
        else        state_q <= state_d;
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            WV_OFF:  pwm_out = 1'b0;
            WV_HIGH: pwm_out = 1'b1;
            WV_LOW:  pwm_out = 1'b0;
            default: pwm_out = 1'b0;
        endcase
    end

    AST_FORCED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !mode |=> !pwm_out); // R6

endmodule

// File: rtl/shadow_pwm.sv
module shadow_pwm
    import spwm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [DATA_W/8-1:0] wr_strb,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                sync_in,
    output logic                pwm_out
);

    logic [DATA_W-1:0] act_per;
    logic [DATA_W-1:0] act_cmp;
    logic [DATA_W-1:0] cnt;
    logic [CTRL_W-1:0] ctrl;
    logic              wrap;
    ctrl_dec_t         dec;

    assign dec = decode_ctrl(ctrl);

    spwm_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_strb (wr_strb),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wrap    (wrap),
        .act_per (act_per),
        .act_cmp (act_cmp),
        .ctrl    (ctrl)
    );

    spwm_timebase #(.DATA_W(DATA_W)) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (dec.run),
        .sync_in  (sync_in),
        .sync_dis (dec.sync_dis),
        .per      (act_per),
        .cnt      (cnt),
        .wrap     (wrap)
    );

    spwm_wave #(.DATA_W(DATA_W)) u_wave (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt     (cnt),
        .cmp     (act_cmp),
        .mode    (dec.mode),
        .pol     (dec.pol),
        .pwm_out (pwm_out)
    );

endmodule

// File: tb/sim_shadow_pwm.sv
module sim_shadow_pwm;

    localparam logic [3:0] A_APER = 4'd2, A_ACMP = 4'd3, A_SPER = 4'd4,
                           A_SCMP = 4'd5, A_CTRL = 4'd10, A_NONE = 4'd7;
    localparam logic [15:0] C_RUN_N = 16'h02D0, C_RUN_I = 16'h06D0,
                            C_STOP = 16'h02C0, C_OFF = 16'h00D0,
                            C_OFF_I = 16'h04D0, C_SYNC_ON = 16'h0210;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_strb = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        sync_in = 1'b0;
    logic        pwm_out;

    always #10 clk = ~clk;

    shadow_pwm u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_strb(wr_strb), .rd_addr(rd_addr),
        .rd_data(rd_data), .sync_in(sync_in), .pwm_out(pwm_out)
    );

    int     n_run = 0;
    int     n_fail = 0;
    string  req_q[$];
    longint exp_q[$];
    longint act_q[$];
    event   item_ev;

    function automatic void drain();
        while (act_q.size() > 0) begin
            string  r;
            longint e;
            longint a;
            r = req_q.pop_front();
            e = exp_q.pop_front();
            a = act_q.pop_front();
            n_run++;
            if (a != e) begin
                n_fail++;
                $display("FAIL %s: actual %0d expected %0d", r, a, e);
            end
        end
    endfunction

    // Driver side of the scoreboard
    task automatic check(input string req, input longint act, input longint exp);
        req_q.push_back(req);
        exp_q.push_back(exp);
        act_q.push_back(act);
        ->item_ev;
    endtask

    // Monitor side of the scoreboard
    initial begin
        forever begin
            @(item_ev);
            drain();
        end
    end

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_strb = s;
        @(negedge clk);
        wr_en = 1'b0; wr_strb = '0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #2 d = rd_data;
    endtask

    task automatic set_ctrl(input logic [15:0] c);
        bus_wr(A_CTRL, {c, 16'h0000}, 4'b1100);
    endtask

    task automatic set_both(input logic [31:0] per, input logic [31:0] cmp);
        bus_wr(A_APER, per, 4'hF);
        bus_wr(A_SPER, per, 4'hF);
        bus_wr(A_ACMP, cmp, 4'hF);
        bus_wr(A_SCMP, cmp, 4'hF);
    endtask

    task automatic sample(output logic v);
        @(posedge clk);
        #5 v = pwm_out;
    endtask

    task automatic measure(input int n, output int highs, output int rises);
        logic prev, cur;
        highs = 0; rises = 0;
        sample(prev);
        for (int i = 0; i < n; i++) begin
            sample(cur);
            if (cur) highs++;
            if (cur && !prev) rises++;
            prev = cur;
        end
    endtask

    task automatic wait_fall(output bit ok);
        logic prev, cur;
        ok = 1'b0;
        sample(prev);
        for (int i = 0; i < 300 && !ok; i++) begin
            sample(cur);
            if (prev && !cur) ok = 1'b1;
            prev = cur;
        end
    endtask

    initial begin : watchdog
        #(64'd20 * 64'd150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        logic        v;
        int          hi, ri, lo1, hi1, lo2;
        bit          ok;

        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        sample(v);
        check("R1 pwm low", v, 0);
        bus_rd(A_APER, rd); check("R1 act period", rd, 0);
        bus_rd(A_ACMP, rd); check("R1 act compare", rd, 0);
        bus_rd(A_SPER, rd); check("R1 shd period", rd, 0);
        bus_rd(A_SCMP, rd); check("R1 shd compare", rd, 0);
        bus_rd(A_CTRL, rd); check("R1 control", rd, 0);

        // R2: map, strobes, unmapped
        bus_wr(A_SPER, 32'hA5A5_1234, 4'b1100);
        bus_rd(A_SPER, rd); check("R2 strobe lanes", rd, 32'hA5A5_0000);
        bus_wr(A_NONE, 32'hFFFF_FFFF, 4'hF);
        bus_rd(A_NONE, rd); check("R2 unmapped", rd, 0);
        bus_wr(A_CTRL, 32'hFFFF_FFFF, 4'b0011);
        bus_rd(A_CTRL, rd); check("R2 ctrl low lanes", rd, 0);
        set_both(32'd9, 32'd3);
        set_ctrl(C_RUN_N);
        bus_rd(A_CTRL, rd); check("R2 ctrl readback", rd, 32'h02D0_0000);

        // R3/R4: period 10, high 3
        repeat (20) @(posedge clk);
        measure(100, hi, ri);
        check("R4 high count", hi, 30);
        check("R3 cycle count", ri, 10);

        // R5: inverted polarity
        set_ctrl(C_RUN_I);
        repeat (5) @(posedge clk);
        measure(100, hi, ri);
        check("R5 high count", hi, 70);
        check("R5 cycle count", ri, 10);

        // R4 boundaries
        set_ctrl(C_RUN_N);
        set_both(32'd9, 32'd0);
        repeat (15) @(posedge clk);
        measure(100, hi, ri); check("R4 compare zero", hi, 0);
        set_both(32'd9, 32'd12);
        repeat (15) @(posedge clk);
        measure(100, hi, ri); check("R4 compare above period", hi, 100);

        // R9: minimum period
        set_both(32'd1, 32'd1);
        repeat (10) @(posedge clk);
        measure(100, hi, ri);
        check("R9 high count", hi, 50);
        check("R9 cycle count", ri, 50);

        // R7/R11: mid-cycle shadow retune
        set_both(32'd9, 32'd3);
        repeat (20) @(posedge clk);
        wait_fall(ok);
        check("R7 fall seen", ok, 1);
        fork
            begin
                bus_wr(A_SPER, 32'd19, 4'hF);
                bus_wr(A_SCMP, 32'd10, 4'hF);
            end
            begin
                logic c;
                lo1 = 1; hi1 = 0; lo2 = 0;
                sample(c);
                while (!c && lo1 < 50) begin lo1++; sample(c); end
                while (c && hi1 < 50) begin hi1++; sample(c); end
                while (!c && lo2 < 50) begin lo2++; sample(c); end
            end
        join
        check("R7 old low tail", lo1, 7);
        check("R7 new high", hi1, 10);
        check("R7 new low", lo2, 10);

        // R3/R8: stop, then direct active writes
        set_both(32'd9, 32'd3);
        repeat (20) @(posedge clk);
        wait_fall(ok);
        set_ctrl(C_STOP);
        measure(30, hi, ri); check("R3 stopped holds", hi, 0);
        bus_wr(A_ACMP, 32'd40, 4'hF);
        measure(20, hi, ri); check("R8 direct compare", hi, 20);
        bus_wr(A_SCMP, 32'd0, 4'hF);
        measure(20, hi, ri); check("R7 shadow while stopped", hi, 20);
        bus_wr(A_ACMP, 32'd0, 4'hF);
        measure(20, hi, ri); check("R8 direct compare zero", hi, 0);

        // R6: mode clear forces low
        set_both(32'd9, 32'd40);
        set_ctrl(C_RUN_N);
        repeat (15) @(posedge clk);
        sample(v); check("R4 constant active", v, 1);
        set_ctrl(C_OFF);
        sample(v); check("R6 low after clear", v, 0);
        measure(40, hi, ri); check("R6 stays low", hi, 0);
        set_ctrl(C_OFF_I);
        measure(40, hi, ri); check("R6 low inverted", hi, 0);

        // R10: sync disabled then enabled
        set_both(32'd9, 32'd3);
        set_ctrl(C_RUN_N);
        repeat (20) @(posedge clk);
        wait_fall(ok);
        @(negedge clk) sync_in = 1'b1;
        @(negedge clk) sync_in = 1'b0;
        sample(v); check("R10 sync ignored", v, 0);
        set_ctrl(C_SYNC_ON);
        repeat (5) @(posedge clk);
        wait_fall(ok);
        @(negedge clk) sync_in = 1'b1;
        @(negedge clk) sync_in = 1'b0;
        sample(v); check("R10 sync restarts", v, 1);

        repeat (2) @(posedge clk);
        drain();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule